// File: doc/BRIEF.md
# SDRAM Column Burst Data Path

This block models the data side of a synchronous DRAM once a row is already open. Column commands arrive on a two-bit command bus together with a column address, one per clock at most. A read command walks a burst of words out of a small internal storage array and presents them on the data output after a fixed number of cycles, the CAS latency. A write command stores the word on the data input in the cycle of the command and keeps storing one word per cycle for the rest of the burst.

A new column command may come on any clock. It ends the burst in flight at once and starts its own burst. Reads pass through a latency pipeline, so the words of an interrupted read burst that were already fetched still leave the pipeline. The first word of the new burst follows them with no gap. The output enable is high only in cycles that carry a read word, and the data pins are released (Hi-Z) in every other cycle. The latency (2 or 3) and the burst length (1, 2, 4 or 8) are static settings, sampled only while reset is held.

Top module: `sdram_burst_dp`

## Requirements
- R1: While reset is held and in the first cycle after it, `dq_oe` is low.
- R2: A read command (`cmd` = 2'b01) at column A in cycle c puts the word stored at A on `dq_out`, with `dq_oe` high, in cycle c+L. L is 2 when `cfg_cas3` was 0 at reset and 3 when it was 1.
- R3: A burst that no command interrupts has N words on N consecutive cycles. N is 1, 2, 4 or 8 for `cfg_bl` codes 0, 1, 2 and 3, as sampled at reset.
- R4: Word i of a burst starting at column A uses column (A with its low log2(N) bits cleared) + ((A + i) mod N), so the addresses wrap inside the aligned block of N columns.
- R5: A read command during a read burst cancels the words of the old burst that were not yet fetched. The new burst starts L cycles after the new command, directly after the last old word that was already fetched, with no idle cycle.
- R6: Read commands may come on every clock. Back-to-back reads give one first word per cycle with `dq_oe` held high.
- R7: A write command (`cmd` = 2'b10) at column A stores `dq_in` into A in the command cycle. The following cycles store `dq_in` into the next burst columns in the R4 order.
- R8: A write command during a write burst ends the old burst at once. Columns of the old burst that were not yet written keep their previous contents.
- R9: Commands 2'b00 (no operation) and 2'b11 (deselect) do not stop an active read or write burst.
- R10: `dq_oe` is low in every cycle that carries no read word, including the cycles after the last word of a burst.
- R11: Changes of `cfg_cas3` and `cfg_bl` after reset is released have no effect on latency or burst length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| cfg_cas3 | input | 1 | Latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| cfg_bl | input | 2 | Burst length code: 0→1, 1→2, 2→4, 3→8 words |
| cmd | input | 2 | 00 no operation, 01 read, 10 write, 11 deselect |
| col_addr | input | COL_W | Column address, used in a read or write command cycle |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, zero when not enabled |
| dq_oe | output | 1 | High when `dq_out` carries a read word; low means Hi-Z |

## Verification
Two functions can fall in the same cycle. The latency pipeline is still emptying words of an interrupted burst while the sequencer starts fetching the new burst. The bench provokes this with a second read issued one idle cycle after the first, and with reads on four consecutive cycles. Its reference queue clears every scheduled word that was not yet fetched when the new command came, then schedules the new burst L cycles out. Each cycle is then judged on both the enable and the data, so a gap, a stale extra word or a shifted handover shows up as a mismatch in a named cycle.

// File: rtl/sdram_dp_pkg.sv
`timescale 1ns/1ps
package sdram_dp_pkg;
   typedef enum logic [1:0] {
      CMD_NOP  = 2'b00,
      CMD_RD   = 2'b01,
      CMD_WR   = 2'b10,
      CMD_DSEL = 2'b11
   } col_cmd_e;

   localparam int MAX_BURST = 8;
   localparam int IDX_W     = 3;

   function automatic logic [3:0] bl_words(input logic [1:0] code);
      return 4'd1 << code;
   endfunction
endpackage

// File: rtl/sdram_dp_array.sv
`timescale 1ns/1ps
module sdram_dp_array #(
   parameter int DATA_W = 16,
   parameter int COL_W  = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [COL_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << COL_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/sdram_dp_burst.sv
`timescale 1ns/1ps
module sdram_dp_burst
   import sdram_dp_pkg::*;
#(
   parameter int COL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cmd,
   input  logic [COL_W-1:0] col_addr,
   input  logic [1:0]       bl_code,
   output logic             op_rd,
   output logic             op_wr,
   output logic [COL_W-1:0] op_addr
);
   logic [COL_W-1:0] base_q;
   logic [IDX_W-1:0] idx_q;
   logic             act_q;
   logic             wr_q;

   logic             is_rd, is_wr, start, issue;
   logic [IDX_W-1:0] cur_idx;
   logic [COL_W-1:0] cur_base;
   logic [COL_W-1:0] mask;
   logic [3:0]       nwords;

   always_comb begin
      is_rd    = (cmd == CMD_RD);
      is_wr    = (cmd == CMD_WR);
      start    = is_rd | is_wr;
      issue    = start | act_q;
      nwords   = bl_words(bl_code);
      mask     = COL_W'(nwords - 4'd1);
      cur_idx  = start ? '0 : idx_q;
      cur_base = start ? col_addr : base_q;
      op_addr  = (cur_base & ~mask) | ((cur_base + COL_W'(cur_idx)) & mask);
      op_rd    = start ? is_rd : (act_q & ~wr_q);
      op_wr    = start ? is_wr : (act_q & wr_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         wr_q   <= 1'b0;
         idx_q  <= '0;
         base_q <= '0;
      end else if (issue) begin
         act_q  <= ({1'b0, cur_idx} + 4'd1) < nwords;
         idx_q  <= cur_idx + 1'b1;
         base_q <= cur_base;
         if (start) wr_q <= is_wr;
      end
   end
endmodule

// File: rtl/sdram_dp_rdpipe.sv
`timescale 1ns/1ps
module sdram_dp_rdpipe #(
   parameter  int DATA_W = 16,
   parameter  int MAX_CL = 3,
   localparam int LAT_W  = $clog2(MAX_CL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LAT_W-1:0]  lat,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);
   if (MAX_CL < 2) begin : g_bad_cl
      $error("sdram_dp_rdpipe: MAX_CL must be at least 2");
   end

   logic [MAX_CL-1:0] vld_q;
   logic [DATA_W-1:0] dat_q [MAX_CL];

   always_ff @(posedge clk) begin
      if (!rst_n) vld_q[0] <= 1'b0;
      else        vld_q[0] <= in_vld;
      dat_q[0] <= in_data;
   end

   for (genvar s = 1; s < MAX_CL; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) vld_q[s] <= 1'b0;
         else        vld_q[s] <= vld_q[s-1];
         dat_q[s] <= dat_q[s-1];
      end
   end

   always_comb begin
      out_vld  = 1'b0;
      out_data = '0;
      for (int i = 0; i < MAX_CL; i++) begin
         if (LAT_W'(i + 1) == lat) begin
            out_vld  = vld_q[i];
            out_data = dat_q[i];
         end
      end
   end
endmodule

// File: rtl/sdram_burst_dp.sv
`timescale 1ns/1ps
module sdram_burst_dp
   import sdram_dp_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int COL_W     = 6,
   parameter int MAX_CL    = 3,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cas3,
   input  logic [1:0]        cfg_bl,
   input  logic [1:0]        cmd,
   input  logic [COL_W-1:0]  col_addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   localparam int LAT_W = $clog2(MAX_CL + 1);

   if (COL_W < IDX_W) begin : g_bad_col
      $error("sdram_burst_dp: COL_W must cover the longest burst");
   end
   if (MAX_CL < 3) begin : g_bad_lat
      $error("sdram_burst_dp: MAX_CL must reach latency 3");
   end

   logic              cl3_q;
   logic [1:0]        bl_q;
   logic              op_rd, op_wr;
   logic [COL_W-1:0]  op_addr;
   logic [DATA_W-1:0] rd_data;
   logic              pipe_vld;
   logic [DATA_W-1:0] pipe_data;
   logic [LAT_W-1:0]  lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cl3_q <= cfg_cas3;
         bl_q  <= cfg_bl;
      end
   end

   assign lat = cl3_q ? LAT_W'(3) : LAT_W'(2);

   sdram_dp_burst #(.COL_W(COL_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .col_addr (col_addr),
      .bl_code  (bl_q),
      .op_rd    (op_rd),
      .op_wr    (op_wr),
      .op_addr  (op_addr)
   );

   sdram_dp_array #(.DATA_W(DATA_W), .COL_W(COL_W)) u_mem (
      .clk   (clk),
      .we    (op_wr),
      .addr  (op_addr),
      .wdata (dq_in),
      .rdata (rd_data)
   );

   sdram_dp_rdpipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .lat      (lat),
      .in_vld   (op_rd),
      .in_data  (rd_data),
      .out_vld  (pipe_vld),
      .out_data (pipe_data)
   );

   assign dq_oe = pipe_vld;

   if (ZERO_IDLE) begin : g_zero_idle
      assign dq_out = pipe_vld ? pipe_data : '0;
   end else begin : g_raw_out
      assign dq_out = pipe_data;
   end
endmodule

// File: rtl/sdram_burst_dp_chk.sv
`timescale 1ns/1ps
module sdram_burst_dp_chk #(
   parameter int COL_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cmd,
   input logic [COL_W-1:0] col_addr,
   input logic             dq_oe,
   input logic             cl3_q,
   input logic [1:0]       bl_q,
   input logic             op_wr,
   input logic [COL_W-1:0] op_addr
);
   logic [4:0] rd_age;
   logic [3:0] wr_age;
   logic       last_wr;
   logic [4:0] cl_c;
   logic [4:0] bl_c;

   assign cl_c = cl3_q ? 5'd3 : 5'd2;
   assign bl_c = 5'd1 << bl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_age  <= 5'd31;
         wr_age  <= 4'd15;
         last_wr <= 1'b0;
      end else begin
         if (cmd == 2'b01)       rd_age <= 5'd1;
         else if (rd_age != 31)  rd_age <= rd_age + 5'd1;
         if (cmd == 2'b10) begin
            wr_age  <= 4'd1;
            last_wr <= 1'b1;
         end else begin
            if (wr_age != 15)    wr_age <= wr_age + 4'd1;
            if (cmd == 2'b01)    last_wr <= 1'b0;
         end
      end
   end

   // R2
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_age == cl_c) |-> dq_oe);

   // R10
   idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (rd_age <= cl_c + bl_c - 5'd1));

   // R7
   wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b10) |-> (op_wr && op_addr == col_addr));

   // R9
   nop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == 2'b00 || cmd == 2'b11) && last_wr && {1'b0, wr_age} < bl_c) |-> op_wr);
endmodule

bind sdram_burst_dp sdram_burst_dp_chk #(.COL_W(COL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd      (cmd),
   .col_addr (col_addr),
   .dq_oe    (dq_oe),
   .cl3_q    (cl3_q),
   .bl_q     (bl_q),
   .op_wr    (op_wr),
   .op_addr  (op_addr)
);

// File: tb/sdram_burst_dp_bench.sv
`timescale 1ns/1ps
module sdram_burst_dp_bench;
   localparam int DW = 16;
   localparam int AW = 6;
   localparam int SCH = 1024;
   localparam logic [27:0] NOPV = {2'b00, 6'd0, 16'h0000, 4'd10};
   localparam int NV = 47;
   localparam logic [27:0] VEC [NV] = '{
      {2'b01, 6'd6,  16'h0, 4'd4}, NOPV, NOPV, NOPV, NOPV, NOPV, NOPV,
      {2'b01, 6'd0,  16'h0, 4'd2}, NOPV,
      {2'b01, 6'd13, 16'h0, 4'd5}, NOPV, NOPV, NOPV, NOPV, NOPV, NOPV,
      {2'b01, 6'd20, 16'h0, 4'd6}, {2'b01, 6'd33, 16'h0, 4'd6},
      {2'b01, 6'd46, 16'h0, 4'd6}, {2'b01, 6'd59, 16'h0, 4'd6},
      NOPV, NOPV, NOPV, NOPV, NOPV, NOPV,
      {2'b10, 6'd8,  16'hBEEF, 4'd8}, {2'b10, 6'd17, 16'hCAFE, 4'd8},
      {2'b00, 6'd0,  16'h1111, 4'd9}, {2'b11, 6'd0, 16'h2222, 4'd9},
      {2'b00, 6'd0,  16'h3333, 4'd9}, NOPV, NOPV,
      {2'b01, 6'd8,  16'h0, 4'd8}, NOPV, NOPV, NOPV, NOPV, NOPV, NOPV,
      {2'b01, 6'd16, 16'h0, 4'd9}, NOPV, NOPV, NOPV, NOPV, NOPV, NOPV
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_cas3 = 1'b0;
   logic [1:0]    cfg_bl = 2'd2;
   logic [1:0]    cmd = 2'b00;
   logic [AW-1:0] col_addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int cl = 2;
   int bl = 4;
   logic [DW-1:0] mem [64];
   bit            sch_v [SCH];
   logic [DW-1:0] sch_d [SCH];
   string         sch_t [SCH];
   bit w_act = 0;
   int w_idx = 0;
   int w_base = 0;

   always #5 clk = ~clk;

   sdram_burst_dp u_sdram_burst_dp (
      .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3), .cfg_bl(cfg_bl),
      .cmd(cmd), .col_addr(col_addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   function automatic string tag_name(input int t);
      case (t)
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         9: return "R9";
         11: return "R11";
         default: return "R10";
      endcase
   endfunction

   function automatic int waddr(input int base, input int i);
      return (base & ~(bl - 1)) | ((base + i) & (bl - 1));
   endfunction

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW:0] act, input logic [DW:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s cycle %0d %s: actual %h expected %h", tag, cyc, what, act, exp);
      end
   endtask

   task automatic step(input logic [1:0] c, input int a, input logic [DW-1:0] d,
                       input string tag);
      @(negedge clk);
      if (sch_v[cyc])
         chk(dq_oe === 1'b1 && dq_out === sch_d[cyc], sch_t[cyc], "read word",
             {dq_oe, dq_out}, {1'b1, sch_d[cyc]});
      else
         chk(dq_oe === 1'b0, "R10", "hi-z", {dq_oe, dq_out}, {1'b0, 16'h0});
      cmd = c;
      col_addr = AW'(a);
      dq_in = d;
      if (c == 2'b01 || c == 2'b10) begin
         for (int k = cyc + cl; k < cyc + cl + 9; k++) sch_v[k] = 1'b0;
         w_act = 1'b0;
      end
      if (c == 2'b01) begin
         for (int i = 0; i < bl; i++) begin
            sch_v[cyc + cl + i] = 1'b1;
            sch_d[cyc + cl + i] = mem[waddr(a, i)];
            sch_t[cyc + cl + i] = tag;
         end
      end else if (c == 2'b10) begin
         w_act = 1'b1;
         w_idx = 0;
         w_base = a;
      end
      if (w_act) begin
         mem[waddr(w_base, w_idx)] = d;
         w_idx++;
         if (w_idx == bl) w_act = 1'b0;
      end
      cyc++;
   endtask

   task automatic do_reset(input logic cas3, input logic [1:0] blc);
      @(negedge clk);
      rst_n = 1'b0;
      cmd = 2'b00;
      cfg_cas3 = cas3;
      cfg_bl = blc;
      repeat (3) @(negedge clk);
      // R1: output released while reset is held
      n_cmp++;
      if (dq_oe !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 in reset: actual %b expected 0", dq_oe);
      end
      rst_n = 1'b1;
      cl = cas3 ? 3 : 2;
      bl = 1 << blc;
      w_act = 1'b0;
      for (int k = 0; k < SCH; k++) sch_v[k] = 1'b0;
      cyc = cyc + 4;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
   end

   initial begin
      do_reset(1'b0, 2'd2);
      // R1: first cycle after reset
      step(2'b00, 0, 16'h0, "R1");
      // R7 / R9: fill every column, alternating idle encodings
      for (int b = 0; b < 16; b++) begin
         step(2'b10, b * 4, 16'h4000 + DW'(b * 4), "R7");
         step(2'b00, 0, 16'h4001 + DW'(b * 4), "R9");
         step(2'b11, 0, 16'h4002 + DW'(b * 4), "R9");
         step(2'b00, 0, 16'h4003 + DW'(b * 4), "R9");
      end
      repeat (3) step(2'b00, 0, 16'h0, "R10");
      for (int v = 0; v < NV; v++)
         step(VEC[v][27:26], int'(VEC[v][25:20]), VEC[v][19:4], tag_name(int'(VEC[v][3:0])));
      // R11: latched CL3 / BL8, then inputs changed
      do_reset(1'b1, 2'd3);
      cfg_cas3 = 1'b0;
      cfg_bl = 2'd0;
      step(2'b01, 5, 16'h0, "R11");
      repeat (11) step(2'b00, 0, 16'h0, "R11");
      // R5 at latency 3
      step(2'b01, 2, 16'h0, "R5");
      repeat (3) step(2'b00, 0, 16'h0, "R5");
      step(2'b01, 50, 16'h0, "R5");
      repeat (12) step(2'b00, 0, 16'h0, "R5");
      // R3: single-word bursts
      do_reset(1'b0, 2'd0);
      step(2'b01, 7, 16'h0, "R3");
      step(2'b00, 0, 16'h0, "R3");
      step(2'b01, 9, 16'h0, "R3");
      repeat (5) step(2'b00, 0, 16'h0, "R3");
      // R4 with two-word wrap
      do_reset(1'b0, 2'd1);
      step(2'b01, 3, 16'h0, "R4");
      repeat (5) step(2'b00, 0, 16'h0, "R4");
      report();
   end
endmodule